// File: doc/BRIEF.md
# Collision Backoff Retry Controller

This block handles retries for a node that shares a two-wire open-drain bus with other nodes that can also start transfers. The node's transmitter pulses `start_req` in the cycle where it pulls SDA low to make its start condition. If some other node has already taken SDA low, the bus SDA fell before this node's own edge. The controller counts that as a collision. It then raises `tx_halt` at once, so the transmitter releases both lines, and increments its collision count.

After a collision the controller first waits until the bus has been idle for one full slot. It then draws a random number of slots, and when that wait is over it pulses `retry_go` so the transmitter can repeat its whole access. The random number comes from a truncated binary exponential backoff. A successful transfer clears the collision count. If collisions keep happening without a success in between, the controller gives up.

Top module: `coll_backoff_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after reset, `coll_count` is 0 and `tx_halt`, `retry_go` and `gave_up` are all low.
- R2: A collision occurs when `start_req` is high in the idle state and the SDA sample registered at the previous clock edge is 0. Each collision that does not trigger give-up raises `coll_count` by one after that edge. A `start_req` seen while the previous SDA sample is 1 is a clean start: it does not halt the transmitter and does not change the count.
- R3: `tx_halt` goes high combinationally in the same cycle as the collision. It stays high up to and including the cycle in which `retry_go` is high, and it is low in the cycle after that.
- R4: With n as the collision count after the increment, the exponent is K = min(n, 10). The multiplier r is the low K bits of a 16-bit LFSR. The LFSR is loaded with the seed at reset and advances at every active clock edge: the new value is the old value shifted left by one, with bit 0 set to the XOR of old bits 15, 13, 12 and 10.
- R5: Suppose the bus is idle throughout. Then `retry_go` is high for exactly one cycle, and it rises right after clock edge E0 + S + r·S. Here E0 is the edge that registered the collision and S is the slot length in cycles. The value of r is taken from the LFSR as it stands just before edge E0 + S.
- R6: A clean start puts the controller in the transfer state. There, `xfer_done` clears `coll_count` to 0, while `xfer_abort` returns to idle with the count unchanged.
- R7: During the idle wait, any edge that samples SDA or SCL low restarts the slot. The backoff draw is then taken S edges after the last edge that saw the bus busy.
- R8: On the 16th collision in a row, the controller raises `gave_up` for one cycle, sets `coll_count` to 0, returns to idle and never pulses `retry_go` for that collision.
- R9: `start_req` is ignored from the collision until the retry. It changes neither the count nor the retry timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Pulse: the transmitter is making its own start edge in this cycle |
| xfer_done | input | 1 | Pulse: the transfer finished successfully |
| xfer_abort | input | 1 | Pulse: the transfer ended without success |
| sda_in | input | 1 | Sampled SDA level of the bus |
| scl_in | input | 1 | Sampled SCL level of the bus |
| tx_halt | output | 1 | Transmitter must release the bus and stay off it |
| retry_go | output | 1 | One-cycle pulse: repeat the access now |
| gave_up | output | 1 | One-cycle pulse: collision limit reached |
| coll_count | output | 5 | Consecutive collision count |

## Verification
The cases hardest to reach from the ports are the exponent cap and give-up. Both need ten or more collisions in a row, and each one waits for a random number of slots up to 1023. The bench forces every collision by pulling SDA low one cycle before `start_req`, using a four-cycle slot. It counts active edges and steps its own LFSR to predict each retry edge. A one-cycle SCL dip during the idle wait, and a stray `start_req` inside the wait, exercise the slot restart and the ignore rule.

// File: rtl/bkf_pkg.sv
package bkf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_XFER    = 2'd1,
    ST_HUSH    = 2'd2,
    ST_BACKOFF = 2'd3
  } bkf_state_e;

  // One step of the x^16+x^14+x^13+x^11+1 Fibonacci shift register.
  function automatic logic [15:0] lfsr_step(input logic [15:0] cur);
    return {cur[14:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

  // Backoff exponent: the collision count, truncated at the cap.
  function automatic int unsigned exp_for(input int unsigned n, input int unsigned cap);
    return (n < cap) ? n : cap;
  endfunction

  // Mask keeping the low k bits of a draw.
  function automatic logic [15:0] draw_mask(input int unsigned k);
    return 16'((32'd1 << k) - 32'd1);
  endfunction

endpackage

// File: rtl/bkf_lfsr.sv
module bkf_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] value
);
  import bkf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= SEED;
    else        value <= lfsr_step(value);
  end

endmodule

// File: rtl/bkf_idle_watch.sv
module bkf_idle_watch #(
  parameter int SLOT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sda_in,
  input  logic scl_in,
  output logic slot_met
);
  localparam int IW = $clog2(SLOT_CYCLES + 1);

  logic [IW-1:0] run_len;
  logic          bus_idle;

  assign bus_idle = sda_in & scl_in;
  assign slot_met = enable && bus_idle && (run_len == IW'(SLOT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_len <= '0;
    else if (!enable || !bus_idle) run_len <= '0;
    else if (!slot_met)           run_len <= run_len + 1'b1;
  end

endmodule

// File: rtl/bkf_wait_timer.sv
module bkf_wait_timer #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          zero
);
  logic [TW-1:0] left;

  assign zero = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (load)          left <= load_val;
    else if (run && !zero)  left <= left - 1'b1;
  end

endmodule

// File: rtl/coll_backoff_ctrl.sv
module coll_backoff_ctrl #(
  parameter int          SLOT_CYCLES = 8,
  parameter int          EXP_CAP     = 10,
  parameter int          GIVEUP_AT   = 16,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  localparam int         CW          = $clog2(GIVEUP_AT + 1),
  localparam int         TW          = $clog2(((2 ** EXP_CAP) - 1) * SLOT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          xfer_done,
  input  logic          xfer_abort,
  input  logic          sda_in,
  input  logic          scl_in,
  output logic          tx_halt,
  output logic          retry_go,
  output logic          gave_up,
  output logic [CW-1:0] coll_count
);
  import bkf_pkg::*;

  bkf_state_e    state;
  logic          sda_q;
  logic [15:0]   lfsr_val;
  logic          slot_met;
  logic          timer_zero;

  // Named internal events, visible to the bound checker.
  logic          coll_evt;
  logic          clean_start;
  logic          hit_limit;
  logic          waiting;
  logic          in_xfer;
  logic          load_evt;
  logic [15:0]   r_draw;
  logic [TW-1:0] load_val;

  assign coll_evt    = (state == ST_IDLE) && start_req && !sda_q;
  assign clean_start = (state == ST_IDLE) && start_req && sda_q;
  assign hit_limit   = coll_evt && (coll_count == CW'(GIVEUP_AT - 1));
  assign waiting     = (state == ST_HUSH) || (state == ST_BACKOFF);
  assign in_xfer     = (state == ST_XFER);
  assign load_evt    = (state == ST_HUSH) && slot_met;
  assign r_draw      = lfsr_val & draw_mask(exp_for(int'(coll_count), EXP_CAP));
  assign load_val    = TW'(32'(r_draw) * 32'(SLOT_CYCLES));

  assign tx_halt  = coll_evt || waiting;
  assign retry_go = (state == ST_BACKOFF) && timer_zero;

  bkf_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .value (lfsr_val)
  );

  bkf_idle_watch #(.SLOT_CYCLES(SLOT_CYCLES)) idle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (state == ST_HUSH),
    .sda_in   (sda_in),
    .scl_in   (scl_in),
    .slot_met (slot_met)
  );

  bkf_wait_timer #(.TW(TW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_val (load_val),
    .run      (state == ST_BACKOFF),
    .zero     (timer_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sda_q      <= 1'b1;
      coll_count <= '0;
      gave_up    <= 1'b0;
    end else begin
      sda_q   <= sda_in;
      gave_up <= hit_limit;
      unique case (state)
        ST_IDLE: begin
          if (hit_limit) begin
            coll_count <= '0;
          end else if (coll_evt) begin
            coll_count <= coll_count + 1'b1;
            state      <= ST_HUSH;
          end else if (clean_start) begin
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_done) begin
            coll_count <= '0;
            state      <= ST_IDLE;
          end else if (xfer_abort) begin
            state <= ST_IDLE;
          end
        end
        ST_HUSH: begin
          if (load_evt) state <= ST_BACKOFF;
        end
        ST_BACKOFF: begin
          if (timer_zero) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bkf_checker.sv
module bkf_checker #(
  parameter int SLOT_CYCLES = 8,
  parameter int EXP_CAP     = 10,
  parameter int GIVEUP_AT   = 16,
  parameter int CW          = 5,
  parameter int TW          = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coll_evt,
  input logic          hit_limit,
  input logic          waiting,
  input logic          in_xfer,
  input logic          load_evt,
  input logic [TW-1:0] load_val,
  input logic          xfer_done,
  input logic          sda_in,
  input logic          scl_in,
  input logic          tx_halt,
  input logic          retry_go,
  input logic          gave_up,
  input logic [CW-1:0] coll_count
);

  p_bump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt && !hit_limit |=> coll_count == $past(coll_count) + 1'b1);

  p_halt_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |-> tx_halt);

  p_halt_until_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt && !retry_go && !hit_limit |=> tx_halt);

  p_load_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (int'(load_val) % SLOT_CYCLES == 0) &&
                 (int'(load_val) / SLOT_CYCLES < (2 ** EXP_CAP)));

  p_retry_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |=> !retry_go);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_xfer && xfer_done |=> coll_count == '0);

  p_slot_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> sda_in && scl_in);

  p_giveup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gave_up |-> coll_count == '0 && !waiting);

  p_hold_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> coll_count == $past(coll_count));

endmodule

bind coll_backoff_ctrl bkf_checker #(
  .SLOT_CYCLES (SLOT_CYCLES),
  .EXP_CAP     (EXP_CAP),
  .GIVEUP_AT   (GIVEUP_AT),
  .CW          (CW),
  .TW          (TW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .coll_evt   (coll_evt),
  .hit_limit  (hit_limit),
  .waiting    (waiting),
  .in_xfer    (in_xfer),
  .load_evt   (load_evt),
  .load_val   (load_val),
  .xfer_done  (xfer_done),
  .sda_in     (sda_in),
  .scl_in     (scl_in),
  .tx_halt    (tx_halt),
  .retry_go   (retry_go),
  .gave_up    (gave_up),
  .coll_count (coll_count)
);

// File: tb/coll_backoff_ctrl_tb_top.sv
`timescale 1ns/1ps
module coll_backoff_ctrl_tb_top;

  localparam int          S    = 4;
  localparam int          CAP  = 10;
  localparam int          LIM  = 16;
  localparam logic [15:0] SEED = 16'hACE1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic       xfer_done = 1'b0;
  logic       xfer_abort = 1'b0;
  logic       sda_in = 1'b1;
  logic       scl_in = 1'b1;
  logic       tx_halt, retry_go, gave_up;
  logic [4:0] coll_count;

  int n_checks = 0;
  int n_fail   = 0;
  int ecount   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  coll_backoff_ctrl #(
    .SLOT_CYCLES (S),
    .EXP_CAP     (CAP),
    .GIVEUP_AT   (LIM),
    .LFSR_SEED   (SEED)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .xfer_done  (xfer_done),
    .xfer_abort (xfer_abort),
    .sda_in     (sda_in),
    .scl_in     (scl_in),
    .tx_halt    (tx_halt),
    .retry_go   (retry_go),
    .gave_up    (gave_up),
    .coll_count (coll_count)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Register state after n steps from the seed; feedback is the parity of taps 0xB400.
  function automatic logic [15:0] adv(input int n);
    logic [15:0] x = SEED;
    for (int i = 0; i < n; i++) x = {x[14:0], ^(x & 16'hB400)};
    return x;
  endfunction

  task automatic collide(input int n_exp, input bit bump, input bit poke);
    int n0, ref_edge, k, r, exp_edge, got, guard;
    logic [15:0] lf;
    bit held;
    @(negedge clk); sda_in = 1'b0;
    @(negedge clk); start_req = 1'b1; sda_in = 1'b1;
    #1 chk(tx_halt === 1'b1, "R3 halt in collision cycle", tx_halt, 1);
    n0 = ecount + 1;
    ref_edge = n0;
    @(negedge clk); start_req = 1'b0;
    chk(coll_count == n_exp, "R2 count after collision", coll_count, n_exp);
    held = 1'b1;
    if (bump) begin
      @(negedge clk); scl_in = 1'b0; ref_edge = ecount + 1;
      @(negedge clk); scl_in = 1'b1;
      if (!tx_halt) held = 1'b0;
    end
    if (poke) begin
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
      if (!tx_halt) held = 1'b0;
    end
    k = (n_exp < CAP) ? n_exp : CAP;
    lf = adv(ref_edge + S - 1);
    r = int'(lf) % (1 << k);
    exp_edge = ref_edge + S + r * S;
    guard = 0;
    while (!retry_go && guard < 20000) begin
      if (!tx_halt) held = 1'b0;
      @(negedge clk);
      guard++;
    end
    got = ecount;
    chk(held && tx_halt, "R3 halt held until retry", held, 1);
    chk(got == exp_edge, bump ? "R7 retry edge after busy dip" : "R5 R4 retry edge", got, exp_edge);
    if (poke) chk(coll_count == n_exp, "R9 stray start ignored", coll_count, n_exp);
    @(negedge clk);
    chk(!retry_go && !tx_halt, "R5 retry single cycle, halt released", {retry_go, tx_halt}, 0);
  endtask

  task automatic clean_start;
    @(negedge clk); start_req = 1'b1;
    #1 chk(tx_halt === 1'b0, "R2 clean start not halted", tx_halt, 0);
    @(negedge clk); start_req = 1'b0;
  endtask

  initial begin
    #1;
    chk(coll_count == 0 && !tx_halt && !retry_go && !gave_up, "R1 outputs during reset",
        {coll_count, tx_halt, retry_go, gave_up}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(coll_count == 0 && !tx_halt && !retry_go && !gave_up, "R1 outputs after reset",
        {coll_count, tx_halt, retry_go, gave_up}, 0);

    collide(1, 1'b1, 1'b0);
    collide(2, 1'b0, 1'b1);
    collide(3, 1'b1, 1'b1);

    clean_start();
    chk(coll_count == 3, "R2 clean start keeps count", coll_count, 3);
    @(negedge clk); xfer_abort = 1'b1;
    @(negedge clk); xfer_abort = 1'b0;
    chk(coll_count == 3, "R6 abort keeps count", coll_count, 3);

    clean_start();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk(coll_count == 0, "R6 done clears count", coll_count, 0);

    // Fifteen consecutive collisions sweep every exponent including the cap.
    for (int n = 1; n < LIM; n++) collide(n, 1'b0, 1'b0);

    @(negedge clk); sda_in = 1'b0;
    @(negedge clk); start_req = 1'b1; sda_in = 1'b1;
    #1 chk(tx_halt === 1'b1, "R8 halt on final collision", tx_halt, 1);
    @(negedge clk); start_req = 1'b0;
    chk(gave_up === 1'b1, "R8 give-up pulse", gave_up, 1);
    chk(coll_count == 0, "R8 count cleared on give-up", coll_count, 0);
    begin
      bit quiet = 1'b1;
      @(negedge clk);
      chk(gave_up === 1'b0, "R8 give-up lasts one cycle", gave_up, 0);
      for (int i = 0; i < 60; i++) begin
        if (retry_go || tx_halt) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R8 no retry after give-up", quiet, 1);
    end

    clean_start();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    collide(1, 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule